// File: doc/BRIEF.md
# Front-End Configuration Serializer

This block sends one configuration command to a group of front-end chips over a serial data line. A command has two parts: a command/address field and a data payload of up to 12 bits. The block drives a configuration clock that pulses only while a command is in flight. It also drives a load strobe that tells the receivers whether the current bits belong to the command/address part or to the data part.

The length of each part comes from a 16-bit count word, which is latched when the command is accepted. The three low bits hold the command/address length in units of 8 clock pulses. The thirteen high bits hold the data length in single pulses, with no scaling. For read commands, a readback line from the front-ends can be passed to the block's output. This happens only when readback is enabled, and only from a fixed system-clock offset after the command starts.

Each configuration pulse takes two system clocks: one with the clock low, then one with it high. The data line changes only when the configuration clock falls, so receivers can sample it on the rising edge.

Top module: `fecfg_serializer`

## Requirements
- R1: The command/address phase produces exactly `cntReg[2:0]*8` configuration clock pulses. `ld` is low for all of them.
- R2: The data phase produces exactly `cntReg[15:3]` configuration clock pulses with no scaling. `ld` is high for all of them. For example, `cntReg = 0x0009` gives 8 pulses with `ld` low, then 1 pulse with `ld` high.
- R3: `ld` is low during the whole command/address phase, including its first cycle. It is high for every cycle of the data phase. It is low while idle.
- R4: Command/address bit i (counting from 0) is `caWord[55-i]`. Data bit j is `dataWord[11-j]` for j < 12 and 0 beyond that. A data length below 12 therefore sends only the most significant payload bits.
- R5: Pulse k of a command covers system cycles 2k and 2k+1 after acceptance: `cck` is low in the first cycle and high in the second. `dao` changes only when `cck` falls. While idle, `cck`, `ld`, `dao` and `dto` are all low.
- R6: `busy` rises on the clock edge that accepts `start` and stays high for exactly 2*N cycles, where N is the total number of pulses.
- R7: When the command is a read and readback is enabled, `dto` takes the value of `rbIn` registered at edge k, for every edge k from 19 through 2N-1. Edge 0 is the accepting edge. At every other time, and for commands that are not reads or have readback disabled, `dto` is 0.
- R8: A `start` received while `busy` is high is ignored. `cntReg`, `isRead` and `rbEnable` are latched at acceptance, so later changes to them have no effect on the command in flight.
- R9: A length field of zero skips that phase completely. When both fields are zero, `start` is ignored and `busy` stays low.
- R10: After reset, `busy`, `cck`, `ld`, `dao` and `dto` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send one command |
| caWord | input | 56 | Command/address bits, sent MSB first |
| dataWord | input | 12 | Data payload, sent MSB first |
| cntReg | input | 16 | [2:0] command/address length in units of 8 pulses; [15:3] data length in pulses |
| isRead | input | 1 | Marks the command as a read |
| rbEnable | input | 1 | Allows readback to reach `dto` |
| rbIn | input | 1 | Readback line from the front-ends |
| cck | output | 1 | Gated configuration clock |
| ld | output | 1 | Load strobe, high during the data phase |
| dao | output | 1 | Serial configuration data |
| dto | output | 1 | Registered readback output |
| busy | output | 1 | A command is in flight |

## Verification
The assertions check on every cycle the properties that must always hold:
- a low half of a pulse is always followed by a high half;
- `dao` stays steady while `cck` rises;
- `ld` never drops in the middle of a command;
- the outputs are quiet whenever the block is idle;
- a `start` arriving mid-command leaves the latched lengths untouched.

The bench scenarios cover what depends on the programmed values. They sweep every command/address field value against a set of data lengths and all read/enable combinations. For each command they check:
- the exact pulse counts per phase;
- the bit order, including payload truncation and zero padding;
- the length of the busy window;
- the edge on which readback first appears on `dto` and the edge on which it stops.

// File: rtl/fecfg_pkg.sv
package fecfg_pkg;
  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic loadWords;  // capture caWord/dataWord on acceptance
    logic shiftCa;    // advance the command/address shifter
    logic shiftData;  // advance the payload shifter
    logic selData;    // dao comes from the payload shifter
    logic outEn;      // dao driven only while a command runs
    logic rbSample;   // register rbIn onto dto this edge
  } dpCtl_t;
endpackage

// File: rtl/fecfg_ctrl.sv
module fecfg_ctrl
  import fecfg_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int CA_FIELD_W = 3,
  parameter int CA_SCALE   = 8,
  parameter int RB_START   = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cntReg,
  input  logic             isRead,
  input  logic             rbEnable,
  output logic             busy,
  output logic             cck,
  output logic             ld,
  output dpCtl_t           dpCtl
);
  localparam int DL_W = CNT_W - CA_FIELD_W;
  localparam int SC_W = $clog2(RB_START);
  localparam logic [SC_W-1:0] SC_ARM = SC_W'(RB_START - 1);

  logic            inData;
  logic            rdQ;
  logic [DL_W-1:0] remain;
  logic [DL_W-1:0] dataLenQ;
  logic [SC_W-1:0] sysCnt;

  logic [DL_W-1:0] caLenIn;
  logic [DL_W-1:0] dlIn;
  logic            accept;
  logic            slotEnd;
  logic            phaseSwitch;
  logic            lastSlot;

  assign caLenIn = DL_W'(cntReg[CA_FIELD_W-1:0]) * DL_W'(CA_SCALE);
  assign dlIn    = cntReg[CNT_W-1:CA_FIELD_W];
  assign accept  = start && !busy && ((caLenIn != '0) || (dlIn != '0));

  // a slot ends on the edge that closes the high half of cck
  assign slotEnd     = busy && cck;
  assign phaseSwitch = slotEnd && (remain == DL_W'(1)) && !inData && (dataLenQ != '0);
  assign lastSlot    = slotEnd && (remain == DL_W'(1)) && (inData || (dataLenQ == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cck      <= 1'b0;
      inData   <= 1'b0;
      rdQ      <= 1'b0;
      remain   <= '0;
      dataLenQ <= '0;
      sysCnt   <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      cck      <= 1'b0;
      inData   <= (caLenIn == '0);
      remain   <= (caLenIn == '0) ? dlIn : caLenIn;
      dataLenQ <= dlIn;
      rdQ      <= isRead && rbEnable;
      sysCnt   <= '0;
    end else if (busy) begin
      cck <= !cck;
      if (lastSlot) busy <= 1'b0;
      if (slotEnd) begin
        if (phaseSwitch) begin
          inData <= 1'b1;
          remain <= dataLenQ;
        end else begin
          remain <= remain - DL_W'(1);
        end
      end
      if (sysCnt != SC_ARM) sysCnt <= sysCnt + SC_W'(1);
    end
  end

  assign ld = busy && inData;

  always_comb begin
    dpCtl.loadWords = accept;
    dpCtl.shiftCa   = slotEnd && !inData && !phaseSwitch && !lastSlot;
    dpCtl.shiftData = slotEnd && inData && !lastSlot;
    dpCtl.selData   = inData;
    dpCtl.outEn     = busy;
    dpCtl.rbSample  = busy && rdQ && (sysCnt == SC_ARM) && !lastSlot;
  end

  // R5: the low half of a pulse is always followed by its high half
  p_half_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cck) |=> (busy && cck));

  // R3: the load strobe never drops while the command is still running
  p_ld_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (ld || !busy));

  // R8: a start during a running command leaves the latched lengths alone
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !cck) |=> ($stable(remain) && $stable(dataLenQ)));
endmodule

// File: rtl/fecfg_dp.sv
module fecfg_dp
  import fecfg_pkg::*;
#(
  parameter int CA_W   = 56,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            dpCtl,
  input  logic [CA_W-1:0]   caWord,
  input  logic [DATA_W-1:0] dataWord,
  input  logic              rbIn,
  output logic              dao,
  output logic              dto
);
  logic [CA_W-1:0]   caShift;
  logic [DATA_W-1:0] dataShift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caShift   <= '0;
      dataShift <= '0;
      dto       <= 1'b0;
    end else begin
      if (dpCtl.loadWords) begin
        caShift   <= caWord;
        dataShift <= dataWord;
      end else begin
        if (dpCtl.shiftCa)   caShift   <= {caShift[CA_W-2:0], 1'b0};
        // zeros fill in once the payload is exhausted
        if (dpCtl.shiftData) dataShift <= {dataShift[DATA_W-2:0], 1'b0};
      end
      dto <= dpCtl.rbSample ? rbIn : 1'b0;
    end
  end

  assign dao = dpCtl.outEn &&
               (dpCtl.selData ? dataShift[DATA_W-1] : caShift[CA_W-1]);
endmodule

// File: rtl/fecfg_serializer.sv
module fecfg_serializer
  import fecfg_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int CA_FIELD_W = 3,
  parameter int CA_SCALE   = 8,
  parameter int DATA_W     = 12,
  parameter int RB_START   = 19,
  localparam int CA_W      = ((1 << CA_FIELD_W) - 1) * CA_SCALE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CA_W-1:0]   caWord,
  input  logic [DATA_W-1:0] dataWord,
  input  logic [CNT_W-1:0]  cntReg,
  input  logic              isRead,
  input  logic              rbEnable,
  input  logic              rbIn,
  output logic              cck,
  output logic              ld,
  output logic              dao,
  output logic              dto,
  output logic              busy
);
  dpCtl_t dpCtl;

  fecfg_ctrl #(
    .CNT_W(CNT_W), .CA_FIELD_W(CA_FIELD_W), .CA_SCALE(CA_SCALE), .RB_START(RB_START)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cntReg(cntReg),
    .isRead(isRead), .rbEnable(rbEnable),
    .busy(busy), .cck(cck), .ld(ld), .dpCtl(dpCtl)
  );

  fecfg_dp #(.CA_W(CA_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rst_n(rst_n), .dpCtl(dpCtl), .caWord(caWord),
    .dataWord(dataWord), .rbIn(rbIn), .dao(dao), .dto(dto)
  );

  // R5: dao holds while cck rises, so it only moves when cck falls
  p_dao_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cck) |=> $stable(dao));

  // R10: every output is quiet while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cck && !ld && !dao && !dto));

  // R7: readback never appears outside a running command
  p_dto_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dto |-> busy);
endmodule

// File: tb/sim_fecfg_serializer.sv
`timescale 1ns/1ps
module sim_fecfg_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [55:0] caWord = '0;
  logic [11:0] dataWord = '0;
  logic [15:0] cntReg = '0;
  logic        isRead = 1'b0;
  logic        rbEnable = 1'b0;
  logic        rbIn = 1'b0;
  logic        cck, ld, dao, dto, busy;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  fecfg_serializer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .caWord(caWord), .dataWord(dataWord),
    .cntReg(cntReg), .isRead(isRead), .rbEnable(rbEnable), .rbIn(rbIn),
    .cck(cck), .ld(ld), .dao(dao), .dto(dto), .busy(busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic bit rbPat(input int k, input int s);
    return ((k * 7 + s) % 5) < 2;
  endfunction

  // expected serial bit of slot i (R4)
  function automatic bit expBit(input int i, input int caLen,
                                input logic [55:0] ca, input logic [11:0] dw);
    int j;
    if (i < caLen) return ca[55 - i];
    j = i - caLen;
    if (j < 12) return dw[11 - j];
    return 1'b0;
  endfunction

  task automatic runCmd(input int caF, input int dl, input bit rd, input bit en, input int seed);
    int caLen, total, caPulses, dataPulses, caIdx, dataIdx;
    bit prevCck, expDto, expCck, expLd, expDao, expBusy, poke;
    logic [15:0] cntOrig;
    caLen = caF * 8;
    total = caLen + dl;
    poke  = (2 * total >= 4);
    @(negedge clk);
    caWord   = {$urandom, $urandom};
    dataWord = 12'($urandom);
    cntOrig  = 16'((dl << 3) | caF);
    cntReg   = cntOrig;
    isRead   = rd;
    rbEnable = en;
    start    = 1'b1;
    rbIn     = rbPat(0, seed);
    caPulses = 0; dataPulses = 0; caIdx = 0; dataIdx = 0; prevCck = 1'b0;
    for (int k = 0; k <= 2 * total + 1; k++) begin
      @(negedge clk);  // outputs now reflect edge k
      expBusy = (k < 2 * total);
      expCck  = expBusy && (k % 2 == 1);
      expLd   = expBusy && ((k / 2) >= caLen);
      expDao  = expBusy && expBit(k / 2, caLen, caWord, dataWord);
      expDto  = rd && en && (k >= 19) && (k <= 2 * total - 1) && rbPat(k, seed);
      check("R6 busy window", busy, expBusy);
      check("R5 cck shape", cck, expCck);
      check("R3 ld level", ld, expLd);
      check("R4 dao bit", dao, expDao);
      check("R7 readback dto", dto, expDto);
      // rebuild the stream on each rising cck
      if (cck && !prevCck) begin
        if (ld) begin
          check("R4 data bit order", dao, expBit(caLen + dataIdx, caLen, caWord, dataWord));
          dataPulses++; dataIdx++;
        end else begin
          check("R4 ca bit order", dao, expBit(caIdx, caLen, caWord, dataWord));
          caPulses++; caIdx++;
        end
      end
      prevCck = cck;
      // R8: stimulus at edge 3 that must be ignored
      if (poke && (k + 1 == 3)) begin
        start = 1'b1; cntReg = ~cntOrig; isRead = ~rd; rbEnable = ~en;
      end else begin
        start = 1'b0; cntReg = cntOrig; isRead = rd; rbEnable = en;
      end
      rbIn = rbPat(k + 1, seed);
    end
    check("R1 ca pulse count", caPulses, caLen);
    check("R2 data pulse count", dataPulses, dl);
    if (caF == 0) check("R9 ca phase skipped", caPulses, 0);
    if (dl == 0)  check("R9 data phase skipped", dataPulses, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    int dls[8] = '{0, 1, 3, 8, 9, 12, 13, 21};
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy", busy, 0);
    check("R10 cck", cck, 0);
    check("R10 ld", ld, 0);
    check("R10 dao", dao, 0);
    check("R10 dto", dto, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: both lengths zero, start must be ignored
    cntReg = 16'h0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R9 zero command busy", busy, 0);
      check("R9 zero command cck", cck, 0);
      @(negedge clk);
    end
    // R1/R2: count word 0x0009 gives 8 + 1 pulses
    runCmd(1, 1, 1'b0, 1'b0, 3);
    // sweep of lengths and read/enable combinations
    for (int c = 0; c < 8; c++) begin
      for (int d = 0; d < 8; d++) begin
        int combo;
        combo = (c + d) % 4;
        runCmd(c, dls[d], combo[0], combo[1] | (d == 7), c * 8 + d);
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule